// File: doc/BRIEF.md
# Transponder Configuration Memory Controller

This block is the control logic behind the non-volatile memory of a contactless tag. The memory is modelled as registers grouped into 32-bit blocks. Each block also has a lock bit. Page 0 offers eight blocks. Page 1 offers four addresses: its address 0 is an alias of page 0 block 0, and its addresses 1 to 3 are three blocks of their own. That gives eleven physical blocks of 33 bits. A downlink decoder upstream hands over commands that are already decoded. Each command carries an opcode, a page, a block address, a data word and a lock request. The controller answers reads one whole block at a time. It programs whole blocks after a fixed programming delay.

Two configuration registers mirror fixed blocks. The mode register mirrors page 0 block 0 and the option register mirrors page 1 block 3. Both are loaded once after reset and refreshed on every accepted read. A completed write to either block updates its register. Writes to locked blocks are refused. So are addresses outside a page and reserved opcodes. Each refusal produces a one-cycle error pulse.

Top module: `tcm_ctrl`

## Requirements
- R1: Page 0 accepts addresses 0 to 7. Page 1 accepts addresses 0 to 3, and page 1 address 0 reaches the same storage as page 0 address 0. That makes eleven distinct 32-bit blocks, each with its own lock bit.
- R2: After reset, every block is zero and unlocked, except page 0 block 0, which holds MODE_INIT, and page 1 block 3, which holds OPT_INIT. While reset is held, `busy` is 1 and both configuration outputs are 0. One clock edge after reset is released, `busy` is 0, `mode_reg` equals MODE_INIT and `opt_reg` equals OPT_INIT.
- R3: A read (`cmd_op` = 2'b01) accepted at one edge to a legal address drives `rd_valid` high after that edge, together with the block's data on `rd_data` and its lock bit on `rd_lock`. `err` stays 0.
- R4: On an accepted read, `mode_reg` and `opt_reg` are reloaded from page 0 block 0 and page 1 block 3. They show those blocks' contents in the same cycle as `rd_valid`.
- R5: A write (`cmd_op` = 2'b10) to a legal, unlocked block holds `busy` high for exactly PROG_CYCLES cycles. At the edge where `busy` falls, the block takes `cmd_data` and its lock bit takes `cmd_lock`.
- R6: While `busy` is high, commands are ignored. No `rd_valid` and no `err` follow, and no stored block changes.
- R7: A write to a block whose lock bit is 1 is refused. `err` pulses for one cycle, `busy` stays 0, and the block's data and lock bit are unchanged. Lock bits never clear and locked data never changes.
- R8: A command with an address outside its page, or with opcode 2'b00 or 2'b11, is refused. `err` pulses for one cycle, `rd_valid` and `busy` stay 0, and nothing is stored.
- R9: A completed write to page 0 block 0 (or to its page 1 alias) updates `mode_reg`. A completed write to page 1 block 3 updates `opt_reg`. In both cases the update happens at the edge where `busy` falls.
- R10: `rd_valid` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 01 read, 10 write, others reserved |
| cmd_page | input | 1 | Page select |
| cmd_addr | input | ADDR_W | Block address within the page |
| cmd_data | input | DATA_W | Write data |
| cmd_lock | input | 1 | Lock bit to store with the write |
| rd_data | output | DATA_W | Read block data |
| rd_lock | output | 1 | Read block lock bit |
| rd_valid | output | 1 | Read result valid for one cycle |
| busy | output | 1 | Boot load or programming in progress |
| err | output | 1 | One-cycle refusal pulse |
| mode_reg | output | DATA_W | Mode configuration register |
| opt_reg | output | DATA_W | Option configuration register |

## Verification
Some rules are checked by the assertions on every cycle. Lock bits never clear and locked data stays frozen. `rd_valid` and `err` never coincide. No response follows a busy cycle. A completed write to the mode block lands in the mode register. Other behaviour only the bench's scenarios can show. That covers the exact length of the programming delay and the page 1 alias reaching the same storage. It also covers a refused write leaving its block intact when read back, and a read issued during programming that is never executed.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_RSVD  = 2'b11
  } tcm_op_e;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_IDLE = 2'd1,
    ST_PROG = 2'd2
  } tcm_state_e;

  // Physical block index: page 1 address 0 aliases page 0 block 0,
  // page 1 addresses 1.. follow the page 0 blocks.
  function automatic int unsigned tcm_index(input logic page,
                                            input int unsigned addr,
                                            input int unsigned p0_blocks);
    if (page && addr != 0) return p0_blocks + addr - 1;
    return addr;
  endfunction

  function automatic logic tcm_addr_ok(input logic page,
                                       input int unsigned addr,
                                       input int unsigned p0_blocks,
                                       input int unsigned p1_blocks);
    if (page) return addr < p1_blocks;
    return addr < p0_blocks;
  endfunction

endpackage

// File: rtl/tcm_store.sv
module tcm_store #(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_BLOCKS = 11,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned MODE_IDX   = 0,
  parameter int unsigned OPT_IDX    = 10,
  parameter logic [DATA_W-1:0] MODE_INIT = '0,
  parameter logic [DATA_W-1:0] OPT_INIT  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wlock,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rlock,
  output logic [DATA_W-1:0] mode_tap,
  output logic [DATA_W-1:0] opt_tap
);

  logic [DATA_W-1:0] data_w [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] lock_w;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    localparam logic [DATA_W-1:0] INIT =
      (g == MODE_IDX) ? MODE_INIT : ((g == OPT_IDX) ? OPT_INIT : '0);
    logic [DATA_W-1:0] d_q;
    logic              l_q;
    logic              hit;

    assign hit = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_q <= INIT;
        l_q <= 1'b0;
      end else if (hit) begin
        d_q <= wdata;
        l_q <= wlock;
      end
    end

    assign data_w[g] = d_q;
    assign lock_w[g] = l_q;

    // R7: a lock bit, once set, never clears
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      l_q |=> l_q);
    // R7: locked data never changes
    a_r7_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      l_q |=> $stable(d_q));
  end

  always_comb begin
    rdata = '0;
    rlock = 1'b0;
    if (int'(ridx) < NUM_BLOCKS) begin
      rdata = data_w[ridx];
      rlock = lock_w[ridx];
    end
  end

  assign mode_tap = data_w[MODE_IDX];
  assign opt_tap  = data_w[OPT_IDX];

endmodule

// File: rtl/tcm_seq.sv
module tcm_seq
  import tcm_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned P0_BLOCKS   = 8,
  parameter int unsigned P1_BLOCKS   = 4,
  parameter int unsigned PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_page,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_lock,
  input  logic              tgt_lock,
  output logic [IDX_W-1:0]  tgt_idx,
  output logic              boot_load,
  output logic              rd_fire,
  output logic              bad_fire,
  output logic              commit,
  output logic              busy,
  output logic [IDX_W-1:0]  w_idx,
  output logic [DATA_W-1:0] w_data,
  output logic              w_lock
);

  localparam int unsigned CNT_W = $clog2(PROG_CYCLES) + 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  tcm_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic           accept;
  logic           in_range;
  logic           wr_fire;

  assign accept   = cmd_valid && (state_q == ST_IDLE);
  assign in_range = tcm_addr_ok(cmd_page, int'(cmd_addr), P0_BLOCKS, P1_BLOCKS);
  assign tgt_idx  = IDX_W'(tcm_index(cmd_page, int'(cmd_addr), P0_BLOCKS));

  assign rd_fire  = accept && in_range && (tcm_op_e'(cmd_op) == OP_READ);
  assign wr_fire  = accept && in_range && (tcm_op_e'(cmd_op) == OP_WRITE) && !tgt_lock;
  assign bad_fire = accept && !rd_fire && !wr_fire;

  assign boot_load = (state_q == ST_BOOT);
  assign commit    = (state_q == ST_PROG) && (cnt_q == '0);
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      cnt_q   <= '0;
      w_idx   <= '0;
      w_data  <= '0;
      w_lock  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_BOOT: state_q <= ST_IDLE;
        ST_IDLE: begin
          if (wr_fire) begin
            state_q <= ST_PROG;
            cnt_q   <= CNT_LOAD;
            w_idx   <= tgt_idx;
            w_data  <= cmd_data;
            w_lock  <= cmd_lock;
          end
        end
        ST_PROG: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R5: the commit edge ends the busy period
  a_r5_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);
  // R7/R8: a refused command never starts programming
  a_r8_refusal_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> !busy);
  // R6: nothing is accepted while busy
  a_r6_busy_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(rd_fire || bad_fire));

endmodule

// File: rtl/tcm_cfg.sv
module tcm_cfg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned MODE_IDX = 0,
  parameter int unsigned OPT_IDX  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_load,
  input  logic              rd_fire,
  input  logic              commit,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  input  logic [DATA_W-1:0] mode_tap,
  input  logic [DATA_W-1:0] opt_tap,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] opt_q
);

  logic hit_mode;
  logic hit_opt;

  assign hit_mode = commit && (w_idx == IDX_W'(MODE_IDX));
  assign hit_opt  = commit && (w_idx == IDX_W'(OPT_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      opt_q  <= '0;
    end else if (boot_load || rd_fire) begin
      mode_q <= mode_tap;
      opt_q  <= opt_tap;
    end else begin
      if (hit_mode) mode_q <= w_data;
      if (hit_opt)  opt_q  <= w_data;
    end
  end

  // R9: a completed write to the mode block lands in the mode register
  a_r9_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mode |=> (mode_q == $past(w_data)));
  // R9: a completed write to the option block lands in the option register
  a_r9_opt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    hit_opt |=> (opt_q == $past(w_data)));

endmodule

// File: rtl/tcm_ctrl.sv
module tcm_ctrl
  import tcm_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned P0_BLOCKS   = 8,
  parameter int unsigned P1_BLOCKS   = 4,
  parameter int unsigned PROG_CYCLES = 64,
  parameter logic [DATA_W-1:0] MODE_INIT = 32'h0008_8040,
  parameter logic [DATA_W-1:0] OPT_INIT  = 32'h0000_0C01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_page,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_lock,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_lock,
  output logic              rd_valid,
  output logic              busy,
  output logic              err,
  output logic [DATA_W-1:0] mode_reg,
  output logic [DATA_W-1:0] opt_reg
);

  localparam int unsigned NUM_BLOCKS = P0_BLOCKS + P1_BLOCKS - 1;
  localparam int unsigned IDX_W      = $clog2(NUM_BLOCKS);
  localparam int unsigned MODE_IDX   = 0;
  localparam int unsigned OPT_IDX    = tcm_index(1'b1, 3, P0_BLOCKS);

  logic [IDX_W-1:0]  tgt_idx;
  logic              tgt_lock;
  logic [DATA_W-1:0] tgt_data;
  logic              boot_load;
  logic              rd_fire;
  logic              bad_fire;
  logic              commit;
  logic [IDX_W-1:0]  w_idx;
  logic [DATA_W-1:0] w_data;
  logic              w_lock;
  logic [DATA_W-1:0] mode_tap;
  logic [DATA_W-1:0] opt_tap;

  tcm_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .P0_BLOCKS(P0_BLOCKS), .P1_BLOCKS(P1_BLOCKS), .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_lock(cmd_lock),
    .tgt_lock(tgt_lock), .tgt_idx(tgt_idx),
    .boot_load(boot_load), .rd_fire(rd_fire), .bad_fire(bad_fire),
    .commit(commit), .busy(busy),
    .w_idx(w_idx), .w_data(w_data), .w_lock(w_lock)
  );

  tcm_store #(
    .DATA_W(DATA_W), .NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W),
    .MODE_IDX(MODE_IDX), .OPT_IDX(OPT_IDX),
    .MODE_INIT(MODE_INIT), .OPT_INIT(OPT_INIT)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(commit), .widx(w_idx), .wdata(w_data), .wlock(w_lock),
    .ridx(tgt_idx), .rdata(tgt_data), .rlock(tgt_lock),
    .mode_tap(mode_tap), .opt_tap(opt_tap)
  );

  tcm_cfg #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .MODE_IDX(MODE_IDX), .OPT_IDX(OPT_IDX)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .boot_load(boot_load), .rd_fire(rd_fire), .commit(commit),
    .w_idx(w_idx), .w_data(w_data),
    .mode_tap(mode_tap), .opt_tap(opt_tap),
    .mode_q(mode_reg), .opt_q(opt_reg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_lock  <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      err      <= bad_fire;
      if (rd_fire) begin
        rd_data <= tgt_data;
        rd_lock <= tgt_lock;
      end
    end
  end

  // R10: a read result and a refusal never coincide
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && err));
  // R4: a read result comes with refreshed configuration registers
  a_r4_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mode_reg == mode_tap && opt_reg == opt_tap));
  // R6: a busy cycle is never followed by a response
  a_r6_quiet_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(rd_valid || err));

endmodule

// File: tb/sim_tcm_ctrl.sv
module sim_tcm_ctrl;

  localparam int unsigned PROG = 5;
  localparam logic [31:0] MINIT = 32'h0008_8040;
  localparam logic [31:0] OINIT = 32'h0000_0C01;
  localparam int NV = 16;

  // {op[38:37], page[36], addr[35:33], lock[32], data[31:0]}
  localparam logic [38:0] VEC [NV] = '{
    {2'b01, 1'b0, 3'd0, 1'b0, 32'h0},
    {2'b01, 1'b1, 3'd3, 1'b0, 32'h0},
    {2'b10, 1'b0, 3'd2, 1'b0, 32'hA5A5_0001},
    {2'b01, 1'b0, 3'd2, 1'b0, 32'h0},
    {2'b10, 1'b0, 3'd0, 1'b0, 32'h1234_5678},
    {2'b10, 1'b1, 3'd3, 1'b1, 32'hCAFE_0003},
    {2'b10, 1'b1, 3'd3, 1'b0, 32'h0000_0000},
    {2'b01, 1'b1, 3'd3, 1'b0, 32'h0},
    {2'b01, 1'b1, 3'd4, 1'b0, 32'h0},
    {2'b10, 1'b1, 3'd7, 1'b0, 32'hDEAD_BEEF},
    {2'b00, 1'b0, 3'd1, 1'b0, 32'h0},
    {2'b11, 1'b0, 3'd1, 1'b0, 32'h0},
    {2'b01, 1'b0, 3'd7, 1'b0, 32'h0},
    {2'b10, 1'b0, 3'd7, 1'b1, 32'hFFFF_FFFF},
    {2'b01, 1'b0, 3'd7, 1'b0, 32'h0},
    {2'b01, 1'b1, 3'd0, 1'b0, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic cmd_page = 1'b0;
  logic [2:0] cmd_addr = 3'd0;
  logic [31:0] cmd_data = 32'h0;
  logic cmd_lock = 1'b0;
  logic [31:0] rd_data, mode_reg, opt_reg;
  logic rd_lock, rd_valid, busy, err;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [31:0] mem [11];
  logic        lk  [11];

  always #4 clk = ~clk;

  tcm_ctrl #(.PROG_CYCLES(PROG), .MODE_INIT(MINIT), .OPT_INIT(OINIT)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_page(cmd_page), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_lock(cmd_lock), .rd_data(rd_data), .rd_lock(rd_lock),
    .rd_valid(rd_valid), .busy(busy), .err(err),
    .mode_reg(mode_reg), .opt_reg(opt_reg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Bench's own view of the block map (R1)
  function automatic int slot(input logic page, input logic [2:0] addr);
    case ({page, addr == 3'd0})
      2'b10:   return 7 + int'(addr);
      default: return int'(addr);
    endcase
  endfunction

  task automatic drive(input logic [1:0] op, input logic page, input logic [2:0] addr,
                       input logic lock, input logic [31:0] data);
    cmd_valid = 1'b1; cmd_op = op; cmd_page = page;
    cmd_addr = addr; cmd_lock = lock; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic page, input logic [2:0] addr,
                         input logic lock, input logic [31:0] data, input string tag);
    bit legal;
    int s;
    int n;
    legal = page ? (addr < 3'd4) : 1'b1;
    s = slot(page, addr);
    drive(op, page, addr, lock, data);
    if (!legal || op == 2'b00 || op == 2'b11) begin
      check({tag, " R8 err"}, 32'(err), 32'd1);
      check({tag, " R8 no rd_valid"}, 32'(rd_valid), 32'd0);
      check({tag, " R8 no busy"}, 32'(busy), 32'd0);
    end else if (op == 2'b01) begin
      check({tag, " R3 rd_valid"}, 32'(rd_valid), 32'd1);
      check({tag, " R3 rd_data"}, rd_data, mem[s]);
      check({tag, " R3 rd_lock"}, 32'(rd_lock), 32'(lk[s]));
      check({tag, " R10 err low"}, 32'(err), 32'd0);
      check({tag, " R4 mode refresh"}, mode_reg, mem[0]);
      check({tag, " R4 opt refresh"}, opt_reg, mem[10]);
    end else if (lk[s]) begin
      check({tag, " R7 err"}, 32'(err), 32'd1);
      check({tag, " R7 no busy"}, 32'(busy), 32'd0);
    end else begin
      n = 0;
      while (busy && n < 100) begin
        n++;
        @(negedge clk);
      end
      check({tag, " R5 busy length"}, 32'(n), 32'(PROG));
      mem[s] = data;
      lk[s] = lock;
      check({tag, " R9 mode reg"}, mode_reg, mem[0]);
      check({tag, " R9 opt reg"}, opt_reg, mem[10]);
    end
  endtask

  initial begin
    for (int i = 0; i < 11; i++) begin
      mem[i] = 32'h0;
      lk[i] = 1'b0;
    end
    mem[0] = MINIT;
    mem[10] = OINIT;

    // R2: reset state
    repeat (3) @(negedge clk);
    check("R2 busy in reset", 32'(busy), 32'd1);
    check("R2 mode zero in reset", mode_reg, 32'h0);
    check("R2 opt zero in reset", opt_reg, 32'h0);
    check("R2 rd_valid low in reset", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 busy after boot", 32'(busy), 32'd0);
    check("R2 mode after boot", mode_reg, MINIT);
    check("R2 opt after boot", opt_reg, OINIT);

    // Vector table (R1, R3, R4, R5, R7, R8, R9, R10)
    for (int v = 0; v < NV; v++) begin
      run_cmd(VEC[v][38:37], VEC[v][36], VEC[v][35:33], VEC[v][32], VEC[v][31:0],
              $sformatf("vec%0d", v));
    end

    // R1: page 1 address 0 reaches the same storage as page 0 address 0
    check("R1 alias content", mem[slot(1'b1, 3'd0)], 32'h1234_5678);

    // R6: commands during programming are ignored
    drive(2'b10, 1'b0, 3'd3, 1'b0, 32'h0BAD_F00D);
    check("R6 busy started", 32'(busy), 32'd1);
    drive(2'b10, 1'b0, 3'd4, 1'b0, 32'h7777_7777);
    check("R6 no err while busy", 32'(err), 32'd0);
    drive(2'b11, 1'b0, 3'd1, 1'b0, 32'h0);
    check("R6 no err on bad op while busy", 32'(err), 32'd0);
    drive(2'b01, 1'b0, 3'd3, 1'b0, 32'h0);
    check("R6 no rd_valid while busy", 32'(rd_valid), 32'd0);
    while (busy) @(negedge clk);
    mem[3] = 32'h0BAD_F00D;
    run_cmd(2'b01, 1'b0, 3'd3, 1'b0, 32'h0, "R6 first write landed");
    run_cmd(2'b01, 1'b0, 3'd4, 1'b0, 32'h0, "R6 ignored write absent");

    // R7: write to a locked page 0 block leaves it intact
    run_cmd(2'b10, 1'b0, 3'd7, 1'b0, 32'h0, "R7 locked p0b7");
    run_cmd(2'b01, 1'b0, 3'd7, 1'b0, 32'h0, "R7 readback p0b7");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule